// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer Unit

This block groups two or three identical down-counting timer channels behind one small register space. A shared header holds a start register, with one run bit per channel, and an optional output control register that keeps a single bit. Each channel has its own register window in that space. The windows do not sit on a regular stride: channel 0 starts at 0x08, channel 1 at 0x14 and channel 2 at 0x20. The decoder picks the window from the address and passes the channel an offset relative to the window's base.

A channel counts down on ticks of its own prescaler while its start bit is set. All channels share the same input clock. When a tick finds the count at zero, the channel reloads the count from its constant register and raises its underflow flag. Each channel drives its own interrupt pin. Parameters decide whether the third channel exists and whether the output control register exists. Any access that decodes to nothing pulses an error output for one cycle. A read of such an offset returns zero.

Top module: `tmr_unit`

## Requirements
- R1: After reset, the start register, the output control register and every channel control and capture register read 0. Every channel's constant and count registers read 0xFFFFFFFF. All interrupt pins are low.
- R2: When output control is enabled, offset 0x00 holds only bit 0 of the written value. Bits 31:1 read as 0.
- R3: Offset 0x04 is the start register. Bit n runs channel n, and each channel starts and stops on its own bit without affecting the others. A read returns the last value written, masked to bits 2:0.
- R4: Channel windows sit at 0x08, 0x14 and 0x20. Within a window, the local offsets are 0x0 for the constant (reload) register, 0x4 for the count, 0x8 for control and 0xC for a read/write capture register, which exists on channel 2 only. Address bits 1:0 are ignored.
- R5: Without the third channel, any access at 0x20 or above pulses the error output, returns 0 on a read and changes nothing. A start write with bit 2 set also pulses the error. Bits 1:0 of that write still apply, and bit 2 reads back as 0.
- R6: An undecoded access returns 0 on a read, pulses the error output in the cycle after the access and changes no state. Undecoded accesses are offset 0x00 when output control is absent, and 0x30 and above when the third channel is present.
- R7: A running channel decrements its count once per prescaler period, with the first tick one full period after the start. A tick at count 0 reloads the count from the constant register and sets the underflow flag, control bit 8. From count N at divide-by-4, the flag rises 4*(N+1) cycles after the start write.
- R8: Interrupt pin n is high exactly when channel n's underflow flag and its interrupt enable, control bit 5, are both set. Each pin depends only on its own channel.
- R9: A control write with bit 8 at 0 clears the underflow flag. A control write with bit 8 at 1 leaves the flag unchanged.
- R10: When an underflow and a control write that clears the flag land in the same cycle, the flag ends up set.
- R11: Control bits 2:0 select the prescaler division. Values 0, 1, 2, 3 and 4 divide by 4, 16, 64, 256 and 1024. Values 5 to 7 also divide by 1024.
- R12: Read data appears on rdData in the cycle after rdEn and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all channels |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Single-cycle write strobe; takes precedence over rdEn |
| rdEn | input | 1 | Single-cycle read strobe |
| addr | input | ADDR_W | Byte offset into the register space |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data |
| errPulse | output | 1 | One-cycle pulse after a rejected access |
| irq | output | 3 | One interrupt per channel; bit 2 is tied low without the third channel |

## Verification
Two events can land in the same clock edge: a channel underflow, and a control-register write from software that clears the flag. The bench provokes this by starting a channel at divide-by-4 with its count at 0. It counts exactly four clock edges and times the clearing write so that it is sampled on the edge where the tick occurs. The result is judged at the interrupt pin, which must be high after that edge. The bench also reads the count register, which must show the reload value, as proof that the underflow really happened in that cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int MAX_CH   = 3;
  localparam int DATA_W   = 32;
  localparam int PRE_W    = 10;
  localparam int PSEL_W   = 3;
  localparam int IE_BIT   = 5;
  localparam int FLAG_BIT = 8;

  // strobes from decode control to datapath
  typedef struct packed {
    logic [MAX_CH-1:0] chSel;
    logic [1:0]        regIdx;
    logic              wr;
    logic              rd;
    logic              startSel;
    logic              outSel;
    logic              bad;
  } accStrobe_t;
endpackage

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter bit HAS_CAPT = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              run,
  input  logic              wrEn,
  input  logic [1:0]        regIdx,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdWord,
  output logic              irq
);
  localparam logic [CNT_W-1:0] CNT_INIT = '1;

  logic [CNT_W-1:0]  reloadQ, cntQ;
  logic [PSEL_W-1:0] pselQ;
  logic              ieQ, flagQ;
  logic [PRE_W-1:0]  preQ;
  logic [DATA_W-1:0] captQ;
  logic              tick, underflow;
  logic              wrReload, wrCnt, wrCtl, wrCapt;

  function automatic logic [PRE_W-1:0] divTop(input logic [PSEL_W-1:0] sel);
    case (sel)
      3'd0:    divTop = PRE_W'(3);
      3'd1:    divTop = PRE_W'(15);
      3'd2:    divTop = PRE_W'(63);
      3'd3:    divTop = PRE_W'(255);
      default: divTop = PRE_W'(1023);
    endcase
  endfunction

  assign wrReload  = wrEn && (regIdx == 2'd0);
  assign wrCnt     = wrEn && (regIdx == 2'd1);
  assign wrCtl     = wrEn && (regIdx == 2'd2);
  assign wrCapt    = wrEn && (regIdx == 2'd3);
  assign tick      = run && (preQ == divTop(pselQ));
  assign underflow = tick && (cntQ == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preQ <= '0;
    end else if (!run || tick) begin
      preQ <= '0;
    end else begin
      preQ <= preQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reloadQ <= CNT_INIT;
      cntQ    <= CNT_INIT;
    end else begin
      if (wrReload) reloadQ <= wrData[CNT_W-1:0];
      if (wrCnt) begin
        cntQ <= wrData[CNT_W-1:0];
      end else if (underflow) begin
        cntQ <= reloadQ;
      end else if (tick) begin
        cntQ <= cntQ - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pselQ <= '0;
      ieQ   <= 1'b0;
      flagQ <= 1'b0;
    end else begin
      if (wrCtl) begin
        pselQ <= wrData[PSEL_W-1:0];
        ieQ   <= wrData[IE_BIT];
      end
      // underflow wins over a clearing write in the same cycle
      if (underflow) begin
        flagQ <= 1'b1;
      end else if (wrCtl) begin
        flagQ <= flagQ & wrData[FLAG_BIT];
      end
    end
  end

  generate
    if (HAS_CAPT) begin : g_capt
      always_ff @(posedge clk) begin
        if (!rstN) begin
          captQ <= '0;
        end else if (wrCapt) begin
          captQ <= wrData;
        end
      end
    end else begin : g_noCapt
      assign captQ = '0;
    end
  endgenerate

  always_comb begin
    rdWord = '0;
    case (regIdx)
      2'd0: rdWord = DATA_W'(reloadQ);
      2'd1: rdWord = DATA_W'(cntQ);
      2'd2: begin
        rdWord[PSEL_W-1:0] = pselQ;
        rdWord[IE_BIT]     = ieQ;
        rdWord[FLAG_BIT]   = flagQ;
      end
      default: rdWord = captQ;
    endcase
  end

  assign irq = flagQ & ieQ;
endmodule

// File: rtl/tmr_unit_ctrl.sv
module tmr_unit_ctrl
  import tmr_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter bit HAS_CH2    = 1'b1,
  parameter bit HAS_OUTCTL = 1'b1
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              startBit2,
  output accStrobe_t        stb
);
  localparam logic [ADDR_W-1:0] START_OFF = ADDR_W'(32'h04);
  localparam logic [ADDR_W-1:0] CH0_BASE  = ADDR_W'(32'h08);
  localparam logic [ADDR_W-1:0] CH1_BASE  = ADDR_W'(32'h14);
  localparam logic [ADDR_W-1:0] CH2_BASE  = ADDR_W'(32'h20);
  localparam logic [ADDR_W-1:0] CH2_END   = ADDR_W'(32'h30);

  logic       access;
  logic [3:0] localOff;

  assign access = wrEn | rdEn;

  // windows are checked from the highest base downward
  always_comb begin
    stb      = '0;
    stb.wr   = wrEn;
    stb.rd   = rdEn & ~wrEn;
    localOff = '0;
    if (access) begin
      if (addr >= CH2_BASE) begin
        if (HAS_CH2 && (addr < CH2_END)) begin
          stb.chSel[2] = 1'b1;
          localOff     = 4'(addr - CH2_BASE);
        end else begin
          stb.bad = 1'b1;
        end
      end else if (addr >= CH1_BASE) begin
        stb.chSel[1] = 1'b1;
        localOff     = 4'(addr - CH1_BASE);
      end else if (addr >= CH0_BASE) begin
        stb.chSel[0] = 1'b1;
        localOff     = 4'(addr - CH0_BASE);
      end else if (addr >= START_OFF) begin
        stb.startSel = 1'b1;
        if (!HAS_CH2 && wrEn && startBit2) stb.bad = 1'b1;
      end else if (HAS_OUTCTL) begin
        stb.outSel = 1'b1;
      end else begin
        stb.bad = 1'b1;
      end
    end
    stb.regIdx = localOff[3:2];
  end
endmodule

// File: rtl/tmr_unit_dp.sv
module tmr_unit_dp
  import tmr_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter bit HAS_CH2 = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  accStrobe_t        stb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              errPulse,
  output logic [MAX_CH-1:0] irq
);
  localparam logic [MAX_CH-1:0] START_MASK = HAS_CH2 ? 3'b111 : 3'b011;

  logic [MAX_CH-1:0] startQ;
  logic              outQ;
  logic [DATA_W-1:0] rdDataQ, rdNext;
  logic              errQ;
  logic [DATA_W-1:0] chRd [MAX_CH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startQ <= '0;
      outQ   <= 1'b0;
    end else begin
      if (stb.wr && stb.startSel) startQ <= wrData[MAX_CH-1:0] & START_MASK;
      if (stb.wr && stb.outSel)   outQ   <= wrData[0];
    end
  end

  generate
    for (genvar ch = 0; ch < MAX_CH; ch++) begin : g_ch
      if (ch < 2 || HAS_CH2) begin : g_inst
        tmr_chan #(
          .CNT_W   (CNT_W),
          .HAS_CAPT(ch == 2)
        ) chan_i (
          .clk   (clk),
          .rstN  (rstN),
          .run   (startQ[ch]),
          .wrEn  (stb.wr & stb.chSel[ch]),
          .regIdx(stb.regIdx),
          .wrData(wrData),
          .rdWord(chRd[ch]),
          .irq   (irq[ch])
        );
      end else begin : g_absent
        assign chRd[ch] = '0;
        assign irq[ch]  = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    rdNext = '0;
    if (stb.outSel)   rdNext = DATA_W'(outQ);
    if (stb.startSel) rdNext = DATA_W'(startQ);
    for (int ch = 0; ch < MAX_CH; ch++) begin
      if (stb.chSel[ch]) rdNext = chRd[ch];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdDataQ <= '0;
      errQ    <= 1'b0;
    end else begin
      if (stb.rd) rdDataQ <= rdNext;
      errQ <= stb.bad;
    end
  end

  assign rdData   = rdDataQ;
  assign errPulse = errQ;
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int CNT_W      = 32,
  parameter bit HAS_CH2    = 1'b1,
  parameter bit HAS_OUTCTL = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              errPulse,
  output logic [MAX_CH-1:0] irq
);
  accStrobe_t stb;

  tmr_unit_ctrl #(
    .ADDR_W    (ADDR_W),
    .HAS_CH2   (HAS_CH2),
    .HAS_OUTCTL(HAS_OUTCTL)
  ) ctrl_i (
    .wrEn     (wrEn),
    .rdEn     (rdEn),
    .addr     (addr),
    .startBit2(wrData[2]),
    .stb      (stb)
  );

  tmr_unit_dp #(
    .CNT_W  (CNT_W),
    .HAS_CH2(HAS_CH2)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .wrData  (wrData),
    .rdData  (rdData),
    .errPulse(errPulse),
    .irq     (irq)
  );
endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk
  import tmr_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter bit HAS_CH2    = 1'b1,
  parameter bit HAS_OUTCTL = 1'b1
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              rdEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic              errPulse,
  input logic [MAX_CH-1:0] irq
);
  localparam logic [ADDR_W-1:0] A_START = ADDR_W'(32'h04);
  localparam logic [ADDR_W-1:0] A_CH0   = ADDR_W'(32'h08);
  localparam logic [ADDR_W-1:0] A_CH2   = ADDR_W'(32'h20);

  AST_ERR_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> $past(wrEn | rdEn)); // R6

  AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (errPulse && $past(rdEn && !wrEn)) |-> (rdData == '0)); // R6

  AST_HIGH_WINDOW_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    (!HAS_CH2 && (wrEn | rdEn) && (addr >= A_CH2)) |=> errPulse); // R5

  AST_START_BIT2_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    (!HAS_CH2 && wrEn && (addr >= A_START) && (addr < A_CH0) && wrData[2]) |=> errPulse); // R5

  AST_OUTCTL_ONE_BIT: assert property (@(posedge clk) disable iff (!rstN)
    (HAS_OUTCTL && rdEn && !wrEn && (addr < A_START)) |=> (rdData[DATA_W-1:1] == '0)); // R2

  AST_NO_THIRD_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    !HAS_CH2 |-> !irq[2]); // R8
endmodule

bind tmr_unit tmr_unit_chk #(
  .ADDR_W    (ADDR_W),
  .HAS_CH2   (HAS_CH2),
  .HAS_OUTCTL(HAS_OUTCTL)
) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .rdEn    (rdEn),
  .addr    (addr),
  .wrData  (wrData),
  .rdData  (rdData),
  .errPulse(errPulse),
  .irq     (irq)
);

// File: tb/tmr_unit_tb_top.sv
module tmr_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEnA = 1'b0, rdEnA = 1'b0, wrEnB = 1'b0, rdEnB = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdDataA, rdDataB;
  logic        errA, errB;
  logic [2:0]  irqA, irqB;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  // full unit
  tmr_unit #(.HAS_CH2(1'b1), .HAS_OUTCTL(1'b1)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEnA), .rdEn(rdEnA), .addr(addr),
    .wrData(wrData), .rdData(rdDataA), .errPulse(errA), .irq(irqA));

  // two channels, no output control register
  tmr_unit #(.HAS_CH2(1'b0), .HAS_OUTCTL(1'b0)) dut2_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEnB), .rdEn(rdEnB), .addr(addr),
    .wrData(wrData), .rdData(rdDataB), .errPulse(errB), .irq(irqB));

  typedef struct {
    bit          sel;
    bit          isRd;
    logic [31:0] data;
    bit          err;
    string       req;
  } item_t;

  item_t expQ[$];
  logic  sawAcc = 1'b0;

  always @(posedge clk) sawAcc <= wrEnA | rdEnA | wrEnB | rdEnB;

  // monitor: compares results the cycle after each access
  always @(negedge clk) begin
    if (sawAcc) begin
      if (expQ.size() == 0) begin
        failures++;
        $display("FAIL scoreboard: result with no expected item");
      end else begin
        item_t it;
        logic [31:0] d;
        logic e;
        it = expQ.pop_front();
        d = it.sel ? rdDataB : rdDataA;
        e = it.sel ? errB : errA;
        checks++;
        if (e !== it.err) begin
          failures++;
          $display("FAIL %s: errPulse=%0b expected %0b", it.req, e, it.err);
        end
        if (it.isRd) begin
          checks++;
          if (d !== it.data) begin
            failures++;
            $display("FAIL %s: rdData=%h expected %h", it.req, d, it.data);
          end
        end
      end
    end
  end

  task automatic wrReg(input bit sel, input logic [7:0] a, input logic [31:0] d,
                       input bit expErr, input string req);
    item_t it;
    it.sel = sel; it.isRd = 1'b0; it.data = '0; it.err = expErr; it.req = req;
    @(negedge clk);
    expQ.push_back(it);
    addr = a; wrData = d;
    if (sel) wrEnB = 1'b1; else wrEnA = 1'b1;
    @(negedge clk);
    wrEnA = 1'b0; wrEnB = 1'b0;
  endtask

  task automatic rdReg(input bit sel, input logic [7:0] a, input logic [31:0] expD,
                       input bit expErr, input string req);
    item_t it;
    it.sel = sel; it.isRd = 1'b1; it.data = expD; it.err = expErr; it.req = req;
    @(negedge clk);
    expQ.push_back(it);
    addr = a;
    if (sel) rdEnB = 1'b1; else rdEnA = 1'b1;
    @(negedge clk);
    rdEnA = 1'b0; rdEnB = 1'b0;
  endtask

  task automatic checkVal(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    checkVal("R1 irq after reset", {29'b0, irqA}, 32'h0);
    rdReg(0, 8'h04, 32'h0, 0, "R1 start reset");
    rdReg(0, 8'h00, 32'h0, 0, "R1 outctl reset");
    rdReg(0, 8'h08, 32'hFFFF_FFFF, 0, "R1 ch0 reload reset");
    rdReg(0, 8'h0C, 32'hFFFF_FFFF, 0, "R1 ch0 count reset");
    rdReg(0, 8'h10, 32'h0, 0, "R1 ch0 control reset");
    rdReg(0, 8'h2C, 32'h0, 0, "R1 ch2 capture reset");

    // R2 output control keeps bit 0 only
    wrReg(0, 8'h00, 32'hFFFF_FFFF, 0, "R2 outctl write");
    rdReg(0, 8'h00, 32'h1, 0, "R2 outctl bit0 only");
    wrReg(0, 8'h00, 32'hFFFF_FFFE, 0, "R2 outctl clear");
    rdReg(0, 8'h00, 32'h0, 0, "R2 outctl cleared");

    // R4 window decode and local offsets, low address bits ignored
    wrReg(0, 8'h08, 32'h0000_0005, 0, "R4 ch0 reload");
    wrReg(0, 8'h14, 32'h0000_1111, 0, "R4 ch1 reload");
    wrReg(0, 8'h20, 32'h0000_2222, 0, "R4 ch2 reload");
    wrReg(0, 8'h2F, 32'hCAFE_0042, 0, "R4 ch2 capture via unaligned addr");
    rdReg(0, 8'h08, 32'h0000_0005, 0, "R4 ch0 reload readback");
    rdReg(0, 8'h15, 32'h0000_1111, 0, "R4 ch1 reload readback");
    rdReg(0, 8'h22, 32'h0000_2222, 0, "R4 ch2 reload readback");
    rdReg(0, 8'h2C, 32'hCAFE_0042, 0, "R4 ch2 capture readback");
    rdReg(0, 8'h18, 32'hFFFF_FFFF, 0, "R4 ch1 count untouched");

    // R12 read data holds across a following write
    rdReg(0, 8'h14, 32'h0000_1111, 0, "R12 read value");
    wrReg(0, 8'h1C, 32'h0, 0, "R12 unrelated write");
    checkVal("R12 rdData held", rdDataA, 32'h0000_1111);

    // R6 undecoded offsets on full unit, write has no effect
    rdReg(0, 8'h30, 32'h0, 1, "R6 read above ch2");
    wrReg(0, 8'h30, 32'hDEAD_BEEF, 1, "R6 write above ch2");
    rdReg(0, 8'h2C, 32'hCAFE_0042, 0, "R6 capture unchanged");
    rdReg(0, 8'h20, 32'h0000_2222, 0, "R6 ch2 reload unchanged");

    // R6/R5 reduced unit
    rdReg(1, 8'h00, 32'h0, 1, "R6 missing outctl read");
    wrReg(1, 8'h00, 32'h1, 1, "R6 missing outctl write");
    rdReg(1, 8'h20, 32'h0, 1, "R5 read missing ch2");
    wrReg(1, 8'h24, 32'h0, 1, "R5 write missing ch2");
    rdReg(1, 8'h0C, 32'hFFFF_FFFF, 0, "R5 ch0 count unchanged");
    wrReg(1, 8'h04, 32'h7, 1, "R5 start bit2 rejected");
    rdReg(1, 8'h04, 32'h3, 0, "R5 start low bits applied");
    wrReg(1, 8'h04, 32'h0, 0, "R5 stop reduced unit");
    checkVal("R5 no third irq", {31'b0, irqB[2]}, 32'h0);

    // R7/R8 underflow timing at divide-by-4, count 2, reload 5
    wrReg(0, 8'h0C, 32'h2, 0, "R7 count setup");
    wrReg(0, 8'h10, 32'h20, 0, "R7 control setup");
    wrReg(0, 8'h04, 32'h1, 0, "R3 start ch0");
    rdReg(0, 8'h04, 32'h1, 0, "R3 start readback");
    // the read above consumed 2 of the 12 cycles
    repeat (9) @(posedge clk);
    @(negedge clk);
    checkVal("R7 irq low before underflow", {31'b0, irqA[0]}, 32'h0);
    @(posedge clk);
    @(negedge clk);
    checkVal("R7 irq high at underflow", {31'b0, irqA[0]}, 32'h1);
    checkVal("R8 other irqs low", {30'b0, irqA[2:1]}, 32'h0);
    wrReg(0, 8'h04, 32'h0, 0, "R3 stop ch0");
    rdReg(0, 8'h0C, 32'h5, 0, "R7 reload after underflow");
    rdReg(0, 8'h10, 32'h120, 0, "R7 flag in control bit 8");
    rdReg(0, 8'h18, 32'hFFFF_FFFF, 0, "R3 ch1 not run");

    // R9 flag clearing
    wrReg(0, 8'h10, 32'h120, 0, "R9 write flag one");
    checkVal("R9 flag kept", {31'b0, irqA[0]}, 32'h1);
    wrReg(0, 8'h10, 32'h20, 0, "R9 write flag zero");
    checkVal("R9 flag cleared", {31'b0, irqA[0]}, 32'h0);
    rdReg(0, 8'h10, 32'h20, 0, "R9 control readback");

    // R8 ch2 own pin
    wrReg(0, 8'h24, 32'h0, 0, "R8 ch2 count");
    wrReg(0, 8'h28, 32'h20, 0, "R8 ch2 control");
    wrReg(0, 8'h04, 32'h4, 0, "R3 start ch2 only");
    repeat (4) @(posedge clk);
    @(negedge clk);
    checkVal("R8 ch2 pin only", {29'b0, irqA}, 32'h4);
    wrReg(0, 8'h04, 32'h0, 0, "R3 stop ch2");
    wrReg(0, 8'h28, 32'h0, 0, "R8 ch2 clear");
    checkVal("R8 ch2 pin low", {29'b0, irqA}, 32'h0);

    // R10 underflow and clearing write in the same cycle
    wrReg(0, 8'h0C, 32'h0, 0, "R10 count setup");
    wrReg(0, 8'h04, 32'h1, 0, "R10 start");
    repeat (3) @(posedge clk);
    wrReg(0, 8'h10, 32'h20, 0, "R10 clear on underflow edge");
    checkVal("R10 flag set wins", {31'b0, irqA[0]}, 32'h1);
    wrReg(0, 8'h04, 32'h0, 0, "R10 stop");
    rdReg(0, 8'h0C, 32'h5, 0, "R10 underflow reloaded");

    // R11 divide-by-16
    wrReg(0, 8'h10, 32'h21, 0, "R11 select div16, clear flag");
    wrReg(0, 8'h0C, 32'h0, 0, "R11 count setup");
    wrReg(0, 8'h04, 32'h1, 0, "R11 start");
    repeat (15) @(posedge clk);
    @(negedge clk);
    checkVal("R11 div16 not yet", {31'b0, irqA[0]}, 32'h0);
    @(posedge clk);
    @(negedge clk);
    checkVal("R11 div16 underflow", {31'b0, irqA[0]}, 32'h1);
    wrReg(0, 8'h04, 32'h0, 0, "R11 stop");

    repeat (3) @(negedge clk);
    checkVal("scoreboard drained", expQ.size(), 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule